// File: doc/BRIEF.md
# Width-Scaled Sequential Multiplier

An unsigned shift-and-add multiplier that computes one product bit per clock. Each operation picks its own width through a single flag sampled with the start pulse. In full-width mode both 32-bit operands are used, and the result is a 64-bit product after 32 iterations. In half-width mode only the low 16 bits of each operand are used, the adder is half as wide, and the 32-bit result is ready after 16 iterations. The upper accumulator half never toggles in this mode.

A caller pulses `start_i` while the block is not busy, with the operands and the width flag. `busy_o` stays high while iterations run. `done_o` then pulses for one cycle. `prod_o` holds the result until the next accepted start.

Top module: `widthscale_mul`

## Requirements
- R1: After synchronous active-low reset, `busy_o`, `done_o` and `prod_o` are all zero.
- R2: With `wide_i`=1 at an accepted start, `prod_o` equals the unsigned 64-bit product of `opa_i` and `opb_i` when `done_o` pulses.
- R3: With `wide_i`=0 at an accepted start, `prod_o[31:0]` equals `opa_i[15:0]*opb_i[15:0]` and `prod_o[63:32]` is zero. Operand bits 31..16 have no effect on the result.
- R4: A full-width operation keeps `busy_o` high for exactly 32 cycles, starting the cycle after the start is sampled. This holds whatever the operand values, including operands with zero upper halves.
- R5: A half-width operation keeps `busy_o` high for exactly 16 cycles, starting the cycle after the start is sampled.
- R6: `done_o` is high for exactly one cycle, immediately after the last busy cycle. It is never high together with `busy_o`.
- R7: `prod_o` stays unchanged from the `done_o` cycle until the next accepted start.
- R8: A start pulse while `busy_o` is high is ignored. Its operands and width flag change neither the result nor the timing of the running operation.
- R9: A start is accepted in any cycle where `busy_o` is low, including the `done_o` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin an operation when not busy |
| wide_i | input | 1 | 1 = 32-bit operands, 0 = 16-bit operands |
| opa_i | input | 32 | Multiplicand |
| opb_i | input | 32 | Multiplier |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle completion pulse |
| prod_o | output | 64 | Product, held until next start |

## Verification
A wrong iteration count or a mode latched at the wrong time shows up as a `busy_o` window that is 16 cycles off. It also shows up as a `done_o` pulse in the wrong cycle, and both are visible within one operation. A bad add, shift or carry corrupts `prod_o`, and this is caught at the first `done_o`. Upper-half leakage in narrow mode shows as nonzero `prod_o[63:32]`. A start that is not ignored while busy shows as a shortened window or a product built from the second operand set.

// File: rtl/wsm_pkg.sv
// Package: shared state encoding for the width-scaled multiplier.
// Assumes: nothing beyond IEEE 1800-2017.
package wsm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } wsm_state_t;
endpackage

// File: rtl/wsm_ctrl.sv
// Module: sequencer. Accepts a start when not running, loads the iteration
// count (W or W/2 by width flag), steps once per cycle, then pulses done.
// Assumes: W even and at least 4.
module wsm_ctrl
    import wsm_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic wide_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);
    localparam int H  = W / 2;
    localparam int CW = $clog2(W) + 1;

    wsm_state_t    state_q;
    logic [CW-1:0] cnt_q;

    assign load_o = start_i && (state_q != ST_RUN);
    assign step_o = (state_q == ST_RUN);
    assign busy_o = (state_q == ST_RUN);
    assign done_o = (state_q == ST_DONE);

    // State and iteration counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else if (load_o) begin
            state_q <= ST_RUN;
            cnt_q   <= wide_i ? CW'(W) : CW'(H);
        end else begin
            case (state_q)
                ST_RUN: begin
                    cnt_q <= cnt_q - CW'(1);
                    if (cnt_q == CW'(1))
                        state_q <= ST_DONE;
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R4/R5/R8: a running count only decrements by one per cycle, start ignored.
    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && cnt_q > CW'(1)) |=> (state_q == ST_RUN && cnt_q == $past(cnt_q) - CW'(1)));
    // R6: done is a single-cycle pulse.
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R6: done only directly after a busy cycle.
    p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(busy_o));
    // R6: never busy and done together.
    p_busy_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));
    // R4/R5: running count stays in range.
    p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (cnt_q != '0 && cnt_q <= CW'(W)));
endmodule

// File: rtl/wsm_accum.sv
// Module: datapath. Holds the multiplicand and a 2W-bit accumulator whose
// low part initially carries the multiplier. Each step conditionally adds the
// multiplicand into the active upper part and shifts right by one.
// Narrow mode works in a W-bit window only; upper W bits stay zero.
// Assumes: load_i and step_i never both high.
module wsm_accum #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic           step_i,
    input  logic           wide_i,
    input  logic [W-1:0]   opa_i,
    input  logic [W-1:0]   opb_i,
    output logic [2*W-1:0] acc_o
);
    localparam int H = W / 2;

    logic           mode_q;
    logic [W-1:0]   a_q;
    logic [2*W-1:0] acc_q;
    logic [2*W-1:0] acc_nxt;
    logic [W:0]     sum_full;
    logic [H:0]     sum_half;

    // Both step variants; the latched mode picks one.
    always_comb begin
        sum_full = {1'b0, acc_q[2*W-1:W]} + (acc_q[0] ? {1'b0, a_q} : '0);
        sum_half = {1'b0, acc_q[W-1:H]}   + (acc_q[0] ? {1'b0, a_q[H-1:0]} : '0);
        if (mode_q)
            acc_nxt = {sum_full, acc_q[W-1:1]};
        else
            acc_nxt = {{W{1'b0}}, sum_half, acc_q[H-1:1]};
    end

    // Operand capture on load, one add-and-shift per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            a_q    <= '0;
            acc_q  <= '0;
        end else if (load_i) begin
            mode_q <= wide_i;
            a_q    <= wide_i ? opa_i : {{H{1'b0}}, opa_i[H-1:0]};
            acc_q  <= wide_i ? {{W{1'b0}}, opb_i} : {{(W+H){1'b0}}, opb_i[H-1:0]};
        end else if (step_i) begin
            acc_q  <= acc_nxt;
        end
    end

    assign acc_o = acc_q;

    // R3: upper accumulator half never leaves zero in narrow mode.
    p_hi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> (acc_q[2*W-1:W] == '0));
    // R7: accumulator idles when neither loaded nor stepped.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> $stable(acc_q));
endmodule

// File: rtl/widthscale_mul.sv
// Module: top of the width-scaled sequential multiplier. Ties sequencer to
// datapath; the product is the accumulator.
// Assumes: operands are valid in the cycle start_i is sampled.
module widthscale_mul #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           wide_i,
    input  logic [W-1:0]   opa_i,
    input  logic [W-1:0]   opb_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [2*W-1:0] prod_o
);
    logic load_w;
    logic step_w;

    wsm_ctrl #(.W(W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .wide_i (wide_i),
        .load_o (load_w),
        .step_o (step_w),
        .busy_o (busy_o),
        .done_o (done_o)
    );

    wsm_accum #(.W(W)) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(load_w),
        .step_i(step_w),
        .wide_i(wide_i),
        .opa_i (opa_i),
        .opb_i (opb_i),
        .acc_o (prod_o)
    );

    // R9/R8: busy rises only from a sampled start.
    p_busy_from_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
    // R7: product steady while done and after it until a new start.
    p_prod_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(prod_o));
endmodule

// File: tb/test_widthscale_mul.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random operations, checked against
// products and cycle counts computed here.
module test_widthscale_mul;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        wide_i = 1'b0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic        busy_o;
    logic        done_o;
    logic [63:0] prod_o;

    int checks = 0;
    int errors = 0;

    widthscale_mul i_widthscale_mul (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .wide_i(wide_i),
        .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .done_o(done_o),
        .prod_o(prod_o)
    );

    always #4 clk = ~clk;

    function automatic logic [63:0] ref_prod(logic [31:0] a, logic [31:0] b, logic w);
        logic [63:0] x, y;
        if (w) begin
            x = {32'd0, a};
            y = {32'd0, b};
        end else begin
            x = {48'd0, a[15:0]};
            y = {48'd0, b[15:0]};
        end
        return x * y;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Runs one operation; intrude=1 pulses a junk start mid-run (R8).
    // Returns at the negedge where done is high.
    task automatic run_op(logic [31:0] a, logic [31:0] b, logic w, logic intrude);
        int cnt = 0;
        logic [63:0] exp = ref_prod(a, b, w);
        start_i = 1'b1; wide_i = w; opa_i = a; opb_i = b;
        @(negedge clk);
        start_i = 1'b0; opa_i = ~a; opb_i = ~b; wide_i = ~w;
        while (busy_o && cnt < 100) begin
            cnt++;
            if (intrude && cnt == 5) begin
                start_i = 1'b1; wide_i = ~w; opa_i = 32'hFFFF_FFFF; opb_i = 32'h1234_5678;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        check(w ? "R4 busy cycles" : "R5 busy cycles", 64'(cnt), w ? 64'd32 : 64'd16);
        check("R6 done after busy", {63'd0, done_o}, 64'd1);
        check(w ? "R2 product" : "R3 product", prod_o, exp);
        if (intrude) check("R8 intrusion ignored", prod_o, exp);
    endtask

    // Finishes an op: done drops next cycle, product holds (R6, R7).
    task automatic settle(logic [63:0] exp);
        @(negedge clk);
        check("R6 done pulse width", {63'd0, done_o}, 64'd0);
        repeat (3) @(negedge clk);
        check("R7 product hold", prod_o, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] a, b;
        logic w;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 reset busy", {63'd0, busy_o}, 64'd0);
        check("R1 reset done", {63'd0, done_o}, 64'd0);
        check("R1 reset product", prod_o, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners.
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0); settle(ref_prod(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1));
        run_op(32'h0000_FFFF, 32'h0000_FFFF, 1'b0, 1'b0); settle(ref_prod(32'hFFFF, 32'hFFFF, 1'b0));
        // R4: zero upper halves still take 32 cycles in wide mode.
        run_op(32'h0000_1234, 32'h0000_00FF, 1'b1, 1'b0); settle(ref_prod(32'h1234, 32'hFF, 1'b1));
        // R3: upper operand bits ignored in narrow mode.
        run_op(32'hABCD_8001, 32'h5A5A_FFFE, 1'b0, 1'b0);
        check("R3 upper half zero", {32'd0, prod_o[63:32]}, 64'd0);
        settle(ref_prod(32'h8001, 32'hFFFE, 1'b0));
        run_op(32'd0, 32'hDEAD_BEEF, 1'b1, 1'b0); settle(64'd0);
        // R8: junk start mid-run, both widths.
        run_op(32'h8000_0001, 32'h7FFF_FFFF, 1'b1, 1'b1); settle(ref_prod(32'h8000_0001, 32'h7FFF_FFFF, 1'b1));
        run_op(32'h0000_0003, 32'h0000_C000, 1'b0, 1'b1); settle(ref_prod(32'h3, 32'hC000, 1'b0));
        // R9: start in the done cycle is accepted.
        run_op(32'h0000_0101, 32'h0000_0202, 1'b0, 1'b0);
        run_op(32'h1357_9BDF, 32'h2468_ACE0, 1'b1, 1'b0);
        check("R9 back-to-back accepted", prod_o, ref_prod(32'h1357_9BDF, 32'h2468_ACE0, 1'b1));
        settle(ref_prod(32'h1357_9BDF, 32'h2468_ACE0, 1'b1));

        // Random operations.
        for (int i = 0; i < 60; i++) begin
            a = $urandom; b = $urandom; w = 1'($urandom);
            run_op(a, b, w, 1'((i % 4) == 0));
            settle(ref_prod(a, b, w));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule